// File: doc/BRIEF.md
# Single-Bus Hardwired Processor Sequencer

This block is a small processor core built around one shared internal bus. A program counter, an instruction register, a memory address register, a memory data register, a sixteen-entry register file and two temporaries (an ALU operand latch and an ALU result latch) all hang off that bus. The ALU adds the bus value to either the operand latch or the constant 4. A hardwired step counter decides, for each clock step, which single register drives the bus and which registers capture it.

Every instruction starts with the same three-step fetch. The fetch reads the word at the program counter, advances the program counter by 4 and leaves a copy of the advanced value in the operand latch. Execution then runs for one to four more steps, depending on the opcode. Memory is reached through an external address, write data, read strobe, write strobe and a completion input. Steps that wait on memory hold the step counter until completion arrives, so memory of any latency can be attached.

The instruction word is 32 bits wide. Bits [31:28] hold the opcode, bits [27:24] hold register field A, bits [23:20] hold register field B, and bits [15:0] hold a signed byte offset. Bits [19:16] are not used. The opcodes are: 0 = add, 1 = load, 2 = store, 3 = add from memory, 4 = relative jump. Every other opcode is undefined.

Top module: `sbus_core`

## Requirements
- R1: While `rstN` is low, `memRead`, `memWrite` and `errFlag` are 0 and `memAddr` is 0. The first memory access after reset is an instruction read at byte address 0.
- R2: Each instruction begins with a read at the current program counter. Unless the instruction is a jump, the next instruction read is at that address plus 4.
- R3: In any clock step, at most one source drives the internal bus. A value moved between registers therefore arrives unchanged.
- R4: Opcode 0 sets register A to the sum of registers A and B, modulo 2^32. It makes no memory access.
- R5: Opcode 1 reads memory at the address held in register B and writes the returned word into register A.
- R6: Opcode 2 writes register A to the address held in register B. `memWData` carries the data only while `memWrite` is high and is 0 at all other times. A read and a write are never requested together.
- R7: Opcode 3 reads memory at the address in register B and adds the returned word to register A.
- R8: Opcode 4 sets the program counter to (instruction address + 4 + sign-extended bits [15:0]). Negative offsets move backward.
- R9: Any opcode from 5 to 15 raises `errFlag` for exactly one cycle. It changes no register or memory, and the next instruction is read at the following address.
- R10: A read or write request stays asserted, and the sequence stays on its waiting step, until `memDone` is sampled high. Results do not depend on the memory latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| memAddr | output | 32 | Byte address for the current memory access |
| memWData | output | 32 | Write data; 0 when no write is pending |
| memRData | input | 32 | Read data, taken when `memDone` is high during a read |
| memRead | output | 1 | Read request, held until completion |
| memWrite | output | 1 | Write request, held until completion |
| memDone | input | 1 | Memory completion for the pending request |
| errFlag | output | 1 | One-cycle pulse on an undefined opcode |

## Verification
The block's tightest coincidence happens in the second fetch step, when memory completes in the same cycle the step is entered. In that one cycle the advanced program counter is written into both the program counter and the operand latch, while the data register captures the returned instruction. The same overlap appears at the end of a store, where completion and the end-of-instruction return to the first step land together.

The bench provokes these cases by giving every memory request a random latency of zero to three cycles. Each bus transaction is then compared, in order, against the sequence predicted by an instruction-level model of the program. If a wrong value is captured or a stall is dropped, it shows up later as a wrong address or wrong store data.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD   = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_ADDM  = 4'd3;
  localparam logic [OP_W-1:0] OP_JUMP  = 4'd4;

  // Which instruction field addresses the register file this step
  typedef enum logic {FLD_A = 1'b0, FLD_B = 1'b1} fieldSel_t;

  // Per-step strobes from the sequencer to the datapath
  typedef struct packed {
    logic      pcIn;
    logic      pcOut;
    logic      marIn;
    logic      mdrIn;    // capture from internal bus
    logic      mdrOut;   // drive internal bus
    logic      mdrExt;   // drive external write data
    logic      mdrCap;   // capture from memory on completion
    logic      irIn;
    logic      yIn;
    logic      zIn;
    logic      zOut;
    logic      rfIn;
    logic      rfOut;
    fieldSel_t rfSel;
    logic      offOut;
    logic      selFour;
    logic      memRd;
    logic      memWr;
  } ctlStrobes_t;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 16,
  localparam int RIDX_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [RIDX_W-1:0] idx,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] rData
);

  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_CNT; i++) regs[i] <= '0;
    end else if (we) begin
      regs[idx] <= wData;
    end
  end

  assign rData = regs[idx];

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath import sbus_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 16,
  parameter int OFF_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRData,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memRead,
  output logic              memWrite,
  output logic [OP_W-1:0]   opcode
);

  localparam int RIDX_W = $clog2(REG_CNT);
  localparam int OP_LSB = DATA_W - OP_W;
  localparam int RA_LSB = OP_LSB - RIDX_W;
  localparam int RB_LSB = RA_LSB - RIDX_W;
  localparam logic [DATA_W-1:0] STEP_BYTES = DATA_W'(4);

  logic [DATA_W-1:0] pc, mar, mdr, y, z;
  logic [OP_W-1:0]   irOp;
  logic [RIDX_W-1:0] irA, irB;
  logic [OFF_W-1:0]  irOff;
  logic              rdPend, wrPend;

  logic [DATA_W-1:0] bus, offExt, aluA, aluSum, rfRData;
  logic [RIDX_W-1:0] rfIdx;

  assign offExt = {{(DATA_W-OFF_W){irOff[OFF_W-1]}}, irOff};

  // AND-OR bus: the sequencer keeps the drive enables one-hot
  assign bus = ({DATA_W{ctl.pcOut}}  & pc)
             | ({DATA_W{ctl.zOut}}   & z)
             | ({DATA_W{ctl.mdrOut}} & mdr)
             | ({DATA_W{ctl.rfOut}}  & rfRData)
             | ({DATA_W{ctl.offOut}} & offExt);

  assign aluA   = ctl.selFour ? STEP_BYTES : y;
  assign aluSum = aluA + bus;
  assign rfIdx  = (ctl.rfSel == FLD_A) ? irA : irB;

  sbus_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk   (clk),
    .rstN  (rstN),
    .we    (ctl.rfIn),
    .idx   (rfIdx),
    .wData (bus),
    .rData (rfRData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      y     <= '0;
      z     <= '0;
      irOp  <= '0;
      irA   <= '0;
      irB   <= '0;
      irOff <= '0;
    end else begin
      if (ctl.pcIn)  pc  <= bus;
      if (ctl.marIn) mar <= bus;
      if (ctl.yIn)   y   <= bus;
      if (ctl.zIn)   z   <= aluSum;
      if (ctl.mdrCap && memDone) mdr <= memRData;
      else if (ctl.mdrIn)        mdr <= bus;
      if (ctl.irIn) begin
        irOp  <= bus[DATA_W-1 -: OP_W];
        irA   <= bus[OP_LSB-1 -: RIDX_W];
        irB   <= bus[RA_LSB-1 -: RIDX_W];
        irOff <= bus[OFF_W-1:0];
      end
    end
  end

  // Request latches: set by the issuing step, cleared by completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend <= 1'b0;
      wrPend <= 1'b0;
    end else begin
      if (ctl.memRd)    rdPend <= 1'b1;
      else if (memDone) rdPend <= 1'b0;
      if (ctl.memWr)    wrPend <= 1'b1;
      else if (memDone) wrPend <= 1'b0;
    end
  end

  assign memAddr  = mar;
  assign memRead  = rdPend;
  assign memWrite = wrPend;
  assign memWData = ctl.mdrExt ? mdr : '0;
  assign opcode   = irOp;

  // R3: single bus driver per step
  p_one_driver_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.pcOut, ctl.zOut, ctl.mdrOut, ctl.rfOut, ctl.offOut}));

  // R10: requests persist until completion
  p_read_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memRead && !memDone) |=> memRead);
  p_write_held_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memWrite && !memDone) |=> memWrite);

  // R6: no overlapping requests, write data quiet outside writes
  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
  p_wdata_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memWData != '0) |-> memWrite);

endmodule

// File: rtl/sbus_control.sv
module sbus_control import sbus_pkg::*; (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            memDone,
  output ctlStrobes_t     ctl,
  output logic            errFlag
);

  localparam int STEP_W = 3;
  localparam logic [STEP_W-1:0] FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step;
  logic waitMem, endInst, stall;

  always_comb begin
    ctl     = '0;
    waitMem = 1'b0;
    endInst = 1'b0;
    errFlag = 1'b0;
    case (step)
      3'd1: begin              // PC -> MAR, read, Z = PC + 4
        ctl.pcOut   = 1'b1;
        ctl.marIn   = 1'b1;
        ctl.memRd   = 1'b1;
        ctl.selFour = 1'b1;
        ctl.zIn     = 1'b1;
      end
      3'd2: begin              // Z -> PC and Y, wait for instruction
        ctl.zOut   = 1'b1;
        ctl.pcIn   = 1'b1;
        ctl.yIn    = 1'b1;
        ctl.mdrCap = 1'b1;
        waitMem    = 1'b1;
      end
      3'd3: begin              // MDR -> IR
        ctl.mdrOut = 1'b1;
        ctl.irIn   = 1'b1;
      end
      3'd4: begin
        case (opcode)
          OP_ADD: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_B; ctl.yIn = 1'b1;
          end
          OP_LOAD, OP_ADDM: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_B;
            ctl.marIn = 1'b1; ctl.memRd = 1'b1;
          end
          OP_STORE: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_B; ctl.marIn = 1'b1;
          end
          OP_JUMP: begin
            ctl.offOut = 1'b1; ctl.zIn = 1'b1;
          end
          default: begin
            errFlag = 1'b1;
            endInst = 1'b1;
          end
        endcase
      end
      3'd5: begin
        case (opcode)
          OP_ADD: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_A; ctl.zIn = 1'b1;
          end
          OP_LOAD: begin
            ctl.mdrCap = 1'b1; waitMem = 1'b1;
          end
          OP_STORE: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_A;
            ctl.mdrIn = 1'b1; ctl.memWr = 1'b1;
          end
          OP_ADDM: begin
            ctl.rfOut = 1'b1; ctl.rfSel = FLD_A; ctl.yIn = 1'b1;
            ctl.mdrCap = 1'b1; waitMem = 1'b1;
          end
          default: begin       // jump: Z -> PC
            ctl.zOut = 1'b1; ctl.pcIn = 1'b1; endInst = 1'b1;
          end
        endcase
      end
      3'd6: begin
        case (opcode)
          OP_ADD: begin
            ctl.zOut = 1'b1; ctl.rfIn = 1'b1; ctl.rfSel = FLD_A;
            endInst = 1'b1;
          end
          OP_LOAD: begin
            ctl.mdrOut = 1'b1; ctl.rfIn = 1'b1; ctl.rfSel = FLD_A;
            endInst = 1'b1;
          end
          OP_STORE: begin
            ctl.mdrExt = 1'b1; waitMem = 1'b1; endInst = 1'b1;
          end
          default: begin       // add from memory: Y + MDR -> Z
            ctl.mdrOut = 1'b1; ctl.zIn = 1'b1;
          end
        endcase
      end
      3'd7: begin              // add from memory: Z -> register A
        ctl.zOut = 1'b1; ctl.rfIn = 1'b1; ctl.rfSel = FLD_A;
        endInst = 1'b1;
      end
      default: endInst = 1'b1;
    endcase
  end

  assign stall = waitMem && !memDone;

  always_ff @(posedge clk) begin
    if (!rstN)        step <= FIRST;
    else if (stall)   step <= step;
    else if (endInst) step <= FIRST;
    else              step <= step + STEP_W'(1);
  end

  // R9: error flag is a single-cycle pulse
  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> !errFlag);

  // R2: a finished instruction is followed by a fetch step
  p_fetch_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (endInst && !stall) |=> (ctl.pcOut && ctl.memRd));

  // R10: a stalled step keeps waiting
  p_stall_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> waitMem);

endmodule

// File: rtl/sbus_core.sv
module sbus_core import sbus_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 16,
  parameter int OFF_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              memRead,
  output logic              memWrite,
  input  logic              memDone,
  output logic              errFlag
);

  ctlStrobes_t     ctl;
  logic [OP_W-1:0] opcode;

  sbus_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (opcode),
    .memDone (memDone),
    .ctl     (ctl),
    .errFlag (errFlag)
  );

  sbus_datapath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT), .OFF_W(OFF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .memDone  (memDone),
    .memRData (memRData),
    .memAddr  (memAddr),
    .memWData (memWData),
    .memRead  (memRead),
    .memWrite (memWrite),
    .opcode   (opcode)
  );

  // R1: no memory request or error while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!memRead && !memWrite && !errFlag) || rstN);

endmodule

// File: tb/sim_sbus_core.sv
`timescale 1ns/1ps
module sim_sbus_core;

  localparam int MEM_WORDS = 1024;
  localparam int NINSN     = 400;
  localparam int MAX_EV    = 1024;
  localparam int LIMIT     = 100000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] memAddr, memWData, memRData;
  logic        memRead, memWrite, memDone, errFlag;

  sbus_core u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memRead(memRead), .memWrite(memWrite),
    .memDone(memDone), .errFlag(errFlag)
  );

  initial forever #2 clk = ~clk;   // 250 MHz

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  always @(posedge clk) cycles <= cycles + 1;

  logic [31:0] dutMem [MEM_WORDS];
  logic [31:0] issMem [MEM_WORDS];
  logic [31:0] issReg [16];

  // expected bus events: kind 0 read, 1 write, 2 error pulse
  int          expKind [MAX_EV];
  logic [31:0] expAddr [MAX_EV];
  logic [31:0] expData [MAX_EV];
  string       expTag  [MAX_EV];
  int          expCount = 0;
  int          evIdx    = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int op, input int a, input int b,
                                      input logic [15:0] off);
    return {op[3:0], a[3:0], b[3:0], 4'b0000, off};
  endfunction

  function automatic logic [31:0] randWord();
    int r;
    int a;
    int b;
    logic [15:0] off;
    r   = int'($urandom % 16);
    a   = int'($urandom % 16);
    b   = int'($urandom % 16);
    off = 16'($urandom);
    if (r < 3)       return enc(0, a, b, off);
    else if (r < 6)  return enc(1, a, b, off);
    else if (r < 9)  return enc(2, a, b, off);
    else if (r < 11) return enc(3, a, b, off);
    else if (r < 14) return enc(4, 0, 0, 16'(($urandom % 3) * 4));
    else             return enc(5 + int'($urandom % 11), a, b, off);
  endfunction

  function automatic void pushEv(input int k, input logic [31:0] ad,
                                 input logic [31:0] da, input string tg);
    expKind[expCount] = k;
    expAddr[expCount] = ad;
    expData[expCount] = da;
    expTag[expCount]  = tg;
    expCount++;
  endfunction

  // Instruction-level model of the requirements
  function automatic void issRun();
    logic [31:0] pc;
    logic [31:0] w;
    logic [31:0] ea;
    logic [31:0] sx;
    int op;
    int a;
    int b;
    string fTag;
    pc   = 32'd0;
    fTag = "R1";
    for (int k = 0; k < 16; k++) issReg[k] = 32'd0;
    for (int n = 0; n < NINSN; n++) begin
      pushEv(0, pc, 32'd0, fTag);
      fTag = "R2";
      w  = issMem[pc[11:2]];
      pc = pc + 32'd4;
      op = int'(w[31:28]);
      a  = int'(w[27:24]);
      b  = int'(w[23:20]);
      sx = {{16{w[15]}}, w[15:0]};
      ea = issReg[b];
      case (op)
        0: issReg[a] = issReg[a] + issReg[b];                       // R4
        1: begin pushEv(0, ea, 32'd0, "R5"); issReg[a] = issMem[ea[11:2]]; end
        2: begin pushEv(1, ea, issReg[a], "R6,R3,R4"); issMem[ea[11:2]] = issReg[a]; end
        3: begin pushEv(0, ea, 32'd0, "R7");
                 issReg[a] = issReg[a] + issMem[ea[11:2]]; end
        4: begin pc = pc + sx; fTag = "R8"; end
        default: begin pushEv(2, 32'd0, 32'd0, "R9"); fTag = "R9"; end
      endcase
    end
  endfunction

  task automatic matchEv(input int k, input logic [31:0] ad, input logic [31:0] da);
    if (evIdx >= expCount) return;
    chk(k == expKind[evIdx], expTag[evIdx], "event kind", 32'(k), 32'(expKind[evIdx]));
    if (k != 2)
      chk(ad == expAddr[evIdx], expTag[evIdx], "address", ad, expAddr[evIdx]);
    if (k == 1)
      chk(da == expData[evIdx], expTag[evIdx], "store data", da, expData[evIdx]);
    evIdx++;
  endtask

  // Memory model with random latency 0..3, driven at the falling edge
  initial begin : memModel
    bit busy;
    bit wasWrite;
    int lat;
    busy = 0; wasWrite = 0; lat = 0;
    memDone = 1'b0;
    memRData = 32'd0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (errFlag) matchEv(2, 32'd0, 32'd0);
        if (memDone) begin
          memDone = 1'b0;
        end else if (memRead || memWrite) begin
          if (!busy) begin
            busy = 1; wasWrite = memWrite; lat = int'($urandom % 4);
          end
          if (lat == 0) begin
            chk(wasWrite == memWrite, "R10", "request kind held", 32'(memWrite), 32'(wasWrite));
            if (memWrite) begin
              matchEv(1, memAddr, memWData);
              dutMem[memAddr[11:2]] = memWData;
            end else begin
              chk(memWData == 32'd0, "R6", "write data idle during read", memWData, 32'd0);
              matchEv(0, memAddr, 32'd0);
              memRData = dutMem[memAddr[11:2]];
            end
            memDone = 1'b1;
            busy = 0;
          end else begin
            lat--;
          end
        end else if (busy) begin
          chk(1'b0, "R10", "request dropped before completion", 32'd0, 32'd1);
          busy = 0;
        end
      end
    end
  end

  initial begin : mainSeq
    void'($urandom(32'h5EED_0C0A));
    rstN = 1'b0;
    for (int i = 0; i < MEM_WORDS; i++) dutMem[i] = randWord();
    // directed corner cases
    dutMem[0]  = enc(4, 0, 0, 16'h0008);  // forward jump to word 3
    dutMem[1]  = enc(15, 2, 3, 16'h1234); // undefined opcode
    dutMem[2]  = enc(4, 0, 0, 16'h0004);  // jump to word 4
    dutMem[3]  = enc(4, 0, 0, 16'hFFF4);  // backward jump to word 1
    dutMem[4]  = enc(1, 1, 0, 16'h0000);  // load r1 from address in r0
    dutMem[5]  = enc(0, 1, 1, 16'h0000);  // r1 doubled
    dutMem[6]  = enc(2, 1, 1, 16'h0000);  // store r1 at address r1
    dutMem[7]  = enc(3, 1, 0, 16'h0000);  // r1 += mem[r0]
    dutMem[8]  = enc(2, 1, 2, 16'h0000);  // store r1 at address r2
    dutMem[9]  = enc(0, 3, 1, 16'h0000);  // r3 += r1
    dutMem[10] = enc(2, 3, 0, 16'h0000);  // store r3 at address r0
    for (int i = 0; i < MEM_WORDS; i++) issMem[i] = dutMem[i];
    issRun();

    repeat (3) begin
      @(negedge clk);
      chk(!memRead && !memWrite, "R1", "no request in reset", {30'd0, memRead, memWrite}, 32'd0);
      chk(!errFlag, "R1", "no error in reset", 32'(errFlag), 32'd0);
      chk(memAddr == 32'd0, "R1", "address in reset", memAddr, 32'd0);
    end
    rstN = 1'b1;

    while (evIdx < expCount && cycles < LIMIT) @(negedge clk);
    if (cycles >= LIMIT)
      chk(1'b0, "watchdog", "run did not finish", 32'(evIdx), 32'(expCount));
    chk(evIdx == expCount, "R2", "all expected events seen", 32'(evIdx), 32'(expCount));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule